// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a 32-bit processor from ordinary execution into an exception handler. It accepts two kinds of request: a prioritised interrupt carrying a three-bit level, and an internal trap that brings its own eight-bit vector number. For each request it runs a fixed series of steps:

- It keeps a private copy of the status register (SR), then switches the SR to supervisor mode and turns tracing off.
- It obtains the vector number. An interrupt gets it from an acknowledge read, and a trap already has it.
- It writes a short four-word frame onto the supervisor stack.
- It reads the handler address from the vector table, which is placed relative to a vector base register (VBR).
- It loads that address into the program counter (PC).

The starting SR, PC and supervisor stack pointer (SSP) are taken from context inputs whenever a sequence begins from idle. The updated values are visible on the outputs at all times.

All memory traffic uses a single port with a valid/ready handshake. Words are written 16 bits at a time, and reads return 32 bits. If a request arrives while a sequence is running, it is held. When the current vector read finishes, the sequencer starts again from the SR copy step, working on its own updated state. It reports completion with a one-cycle pulse only when nothing is left waiting.

Top module: `exc_entry_seq`

## Requirements
- R1: The SR word written to the stack is the SR value before this entry changed it: the ctx_sr input for a start from idle, or the internal SR for a restart.
- R2: After entry, SR bit 13 (supervisor) is 1, and SR bits 15 and 14 (trace) are 0. All other bits keep their values, except the bits that R3 changes.
- R3: For an interrupt, SR bits 10:8 (priority mask) take the serviced level. For a trap, those bits are left unchanged.
- R4: An interrupt causes exactly one read in space 0xF at address {28'hFFFFFFF, 1'b0, level}, and the vector number is taken from mem_rdata[7:0]. A trap causes no such read and uses trap_vec.
- R5: The handler address is read in space 0x5 at vbr + vector*4, and the returned 32-bit value becomes the PC.
- R6: The frame is four word writes in space 0x5, in this order:
  - at SSP-2: format word {4'b0000, 12-bit vector*4}
  - at SSP-4: PC[15:0]
  - at SSP-6: PC[31:16]
  - at SSP-8: the saved SR
- R7: After an entry, the SSP is 8 less than its value when that entry began.
- R8: While mem_valid is high and mem_ready is low, every memory output holds its value.
- R9: A request that arrives during a sequence is kept. After the vector read, the next entry starts from the updated SR/PC/SSP, without going back to the ctx inputs, and done does not pulse between the two entries.
- R10: If a trap and an interrupt are both waiting, the trap is served first.
- R11: done is a single-cycle pulse in the cycle after the last vector-read handshake, with PC, SR and SSP final and busy low.
- R12: During and right after reset, mem_valid, busy and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request strobe |
| irq_level | input | 3 | Interrupt level for the strobe |
| trap_req | input | 1 | Internal trap request strobe |
| trap_vec | input | 8 | Vector number of the trap |
| ctx_sr | input | 16 | SR when starting from idle |
| ctx_pc | input | 32 | PC when starting from idle |
| ctx_ssp | input | 32 | SSP when starting from idle |
| vbr | input | 32 | Vector table base |
| mem_valid | output | 1 | Access request |
| mem_write | output | 1 | 1 for a word write, 0 for a read |
| mem_space | output | 4 | Address space code |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Access completes at this edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Entry complete pulse |
| sr_out | output | 16 | Current SR |
| pc_out | output | 32 | Current PC |
| ssp_out | output | 32 | Current SSP |

## Verification
The main function is driven with four kinds of input:
- A lone interrupt whose mask differs from its level, which shows whether the mask is overwritten and the acknowledge cycle is issued.
- Lone traps with a small vector and with the largest vector, which show that the mask is kept, that no acknowledge happens, and that the full 12-bit offset field is formed.
- A trap raised partway through an interrupt entry, which tests that the request is held and that the second frame is built from the first entry's results.
- A trap and an interrupt raised in the same cycle, which tests the serving order.

Every handshake is checked against a queue predicted by a behavioural model, with ready delays that change from one access to the next.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_COPY  = 3'd1,
    ST_ACK   = 3'd2,
    ST_PUSH  = 3'd3,
    ST_VREAD = 3'd4
  } seq_st_t;

  localparam int SR_W      = 16;
  localparam int SR_T1     = 15;
  localparam int SR_T0     = 14;
  localparam int SR_S      = 13;
  localparam int SR_MASK_L = 8;
  localparam logic [3:0] SPACE_ACK = 4'hF;
  localparam logic [3:0] SPACE_SUP = 4'h5;
  localparam logic [3:0] FMT_SHORT = 4'h0;
  localparam int FRAME_WORDS = 4;
endpackage

// File: rtl/exc_req_latch.sv
module exc_req_latch #(
  parameter int LVL_W = 3,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             trap_req,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic             take,
  output logic             any_pend,
  output logic             sel_irq,
  output logic [LVL_W-1:0] sel_lvl,
  output logic [VEC_W-1:0] sel_vec
);
  logic             trap_v, trap_v_n, irq_v, irq_v_n;
  logic [VEC_W-1:0] trap_vec_q, trap_vec_n;
  logic [LVL_W-1:0] irq_lvl_q, irq_lvl_n;
  logic             clr_trap, clr_irq, keep_trap, keep_irq;

  always_comb begin
    clr_trap   = take & trap_v;
    clr_irq    = take & ~trap_v & irq_v;
    keep_trap  = trap_v & ~clr_trap;
    keep_irq   = irq_v & ~clr_irq;
    trap_v_n   = keep_trap | trap_req;
    irq_v_n    = keep_irq | irq_req;
    trap_vec_n = (trap_req && !keep_trap) ? trap_vec : trap_vec_q;
    irq_lvl_n  = (irq_req && !keep_irq) ? irq_level : irq_lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_v     <= 1'b0;
      irq_v      <= 1'b0;
      trap_vec_q <= '0;
      irq_lvl_q  <= '0;
    end else begin
      trap_v     <= trap_v_n;
      irq_v      <= irq_v_n;
      trap_vec_q <= trap_vec_n;
      irq_lvl_q  <= irq_lvl_n;
    end
  end

  assign any_pend = trap_v | irq_v;
  assign sel_irq  = ~trap_v;
  assign sel_lvl  = irq_lvl_q;
  assign sel_vec  = trap_vec_q;

  // R9: a strobe into an empty slot is held for later service
  assert_trap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_v) |=> trap_v);
  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_v) |=> irq_v);
  // R10: a grant with a trap waiting never consumes the interrupt slot
  assert_trap_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && trap_v && irq_v) |=> irq_v);
endmodule

// File: rtl/exc_sr_ctl.sv
module exc_sr_ctl
  import exc_entry_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic [SR_W-1:0]  sr_in,
  input  logic             is_irq,
  input  logic [LVL_W-1:0] lvl,
  output logic [SR_W-1:0]  sr_mod
);
  always_comb begin
    sr_mod        = sr_in;
    sr_mod[SR_S]  = 1'b1;
    sr_mod[SR_T1] = 1'b0;
    sr_mod[SR_T0] = 1'b0;
    if (is_irq) sr_mod[SR_MASK_L +: LVL_W] = lvl;
  end
endmodule

// File: rtl/exc_frame_gen.sv
module exc_frame_gen
  import exc_entry_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic [1:0]        idx,
  input  logic [VEC_W-1:0]  vec,
  input  logic [ADDR_W-1:0] pc,
  input  logic [SR_W-1:0]   saved_sr,
  output logic [WORD_W-1:0] word
);
  localparam int OFS_W = WORD_W - 4;
  logic [OFS_W-1:0] ofs;

  assign ofs = OFS_W'({vec, 2'b00});

  always_comb begin
    unique case (idx)
      2'd0:    word = {FMT_SHORT, ofs};
      2'd1:    word = pc[WORD_W-1:0];
      2'd2:    word = pc[2*WORD_W-1:WORD_W];
      default: word = saved_sr;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              trap_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic [SR_W-1:0]   ctx_sr,
  input  logic [ADDR_W-1:0] ctx_pc,
  input  logic [ADDR_W-1:0] ctx_ssp,
  input  logic [ADDR_W-1:0] vbr,
  output logic              mem_valid,
  output logic              mem_write,
  output logic [3:0]        mem_space,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic [SR_W-1:0]   sr_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] ssp_out
);
  localparam int WSTEP = WORD_W / 8;
  localparam logic [1:0] LAST_IDX = 2'(FRAME_WORDS - 1);
  localparam logic [ADDR_W-1:0] ACK_BASE = {{(ADDR_W-LVL_W-1){1'b1}}, {(LVL_W+1){1'b0}}};

  seq_st_t           st_q, st_n;
  logic              cur_irq_q, cur_irq_n;
  logic [LVL_W-1:0]  cur_lvl_q, cur_lvl_n;
  logic [VEC_W-1:0]  vec_q, vec_n;
  logic [SR_W-1:0]   sr_q, sr_n, saved_q, saved_n, sr_mod;
  logic [ADDR_W-1:0] pc_q, pc_n, ssp_q, ssp_n;
  logic [1:0]        idx_q, idx_n;
  logic              done_n;
  logic              take, any_pend, sel_irq;
  logic [LVL_W-1:0]  sel_lvl;
  logic [VEC_W-1:0]  sel_vec;
  logic [WORD_W-1:0] frame_word;
  logic [ADDR_W-1:0] push_addr;

  exc_req_latch #(.LVL_W(LVL_W), .VEC_W(VEC_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .irq_req(irq_req), .irq_level(irq_level),
    .trap_req(trap_req), .trap_vec(trap_vec),
    .take(take), .any_pend(any_pend),
    .sel_irq(sel_irq), .sel_lvl(sel_lvl), .sel_vec(sel_vec)
  );

  exc_sr_ctl #(.LVL_W(LVL_W)) u_sr (
    .sr_in(sr_q), .is_irq(cur_irq_q), .lvl(cur_lvl_q), .sr_mod(sr_mod)
  );

  exc_frame_gen #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_frame (
    .idx(idx_q), .vec(vec_q), .pc(pc_q), .saved_sr(saved_q), .word(frame_word)
  );

  assign push_addr = ssp_q - ADDR_W'(WSTEP);

  // next-state process
  always_comb begin
    st_n      = st_q;
    cur_irq_n = cur_irq_q;
    cur_lvl_n = cur_lvl_q;
    vec_n     = vec_q;
    sr_n      = sr_q;
    saved_n   = saved_q;
    pc_n      = pc_q;
    ssp_n     = ssp_q;
    idx_n     = idx_q;
    done_n    = 1'b0;
    take      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (any_pend) begin
        take      = 1'b1;
        cur_irq_n = sel_irq;
        cur_lvl_n = sel_lvl;
        vec_n     = sel_vec;
        sr_n      = ctx_sr;
        pc_n      = ctx_pc;
        ssp_n     = ctx_ssp;
        st_n      = ST_COPY;
      end
      ST_COPY: begin
        saved_n = sr_q;
        sr_n    = sr_mod;
        idx_n   = 2'd0;
        st_n    = cur_irq_q ? ST_ACK : ST_PUSH;
      end
      ST_ACK: if (mem_ready) begin
        vec_n = mem_rdata[VEC_W-1:0];
        st_n  = ST_PUSH;
      end
      ST_PUSH: if (mem_ready) begin
        ssp_n = push_addr;
        idx_n = idx_q + 2'd1;
        if (idx_q == LAST_IDX) st_n = ST_VREAD;
      end
      ST_VREAD: if (mem_ready) begin
        pc_n = mem_rdata;
        if (any_pend) begin
          take      = 1'b1;
          cur_irq_n = sel_irq;
          cur_lvl_n = sel_lvl;
          vec_n     = sel_vec;
          st_n      = ST_COPY;
        end else begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_irq_q <= 1'b0;
      cur_lvl_q <= '0;
      vec_q     <= '0;
      sr_q      <= '0;
      saved_q   <= '0;
      pc_q      <= '0;
      ssp_q     <= '0;
      idx_q     <= '0;
      done      <= 1'b0;
    end else begin
      st_q      <= st_n;
      cur_irq_q <= cur_irq_n;
      cur_lvl_q <= cur_lvl_n;
      vec_q     <= vec_n;
      sr_q      <= sr_n;
      saved_q   <= saved_n;
      pc_q      <= pc_n;
      ssp_q     <= ssp_n;
      idx_q     <= idx_n;
      done      <= done_n;
    end
  end

  // memory port driven from state
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_space = SPACE_SUP;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (st_q)
      ST_ACK: begin
        mem_valid = 1'b1;
        mem_space = SPACE_ACK;
        mem_addr  = ACK_BASE | ADDR_W'(cur_lvl_q);
      end
      ST_PUSH: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = push_addr;
        mem_wdata = frame_word;
      end
      ST_VREAD: begin
        mem_valid = 1'b1;
        mem_addr  = vbr + ADDR_W'({vec_q, 2'b00});
      end
      default: ;
    endcase
  end

  assign busy    = (st_q != ST_IDLE);
  assign sr_out  = sr_q;
  assign pc_out  = pc_q;
  assign ssp_out = ssp_q;

  // R8: an access that is not accepted holds its request
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)
                                   && $stable(mem_space) && $stable(mem_wdata)));
  // R2: supervisor set and trace cleared once the SR copy step ends
  assert_sr_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPY) |=> (sr_q[SR_S] && !sr_q[SR_T1] && !sr_q[SR_T0]));
  // R1: the saved SR is the pre-entry SR
  assert_sr_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COPY) |=> (saved_q == $past(sr_q)));
  // R7: each accepted push lowers the stack pointer by one word
  assert_ssp_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PUSH && mem_ready) |=> (ssp_q == $past(ssp_q) - ADDR_W'(WSTEP)));
  // R6: writes go only to the supervisor space at even addresses
  assert_push_space_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write) |-> (mem_space == SPACE_SUP && !mem_addr[0]));
  // R11: done follows a completed table read and leaves the block idle
  assert_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_valid && mem_ready && !mem_write && mem_space == SPACE_SUP) && !busy));
  // R4: an acknowledge cycle only occurs for an interrupt
  assert_ack_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_space == SPACE_ACK) |-> cur_irq_q);
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0, trap_req = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [7:0]  trap_vec = '0;
  logic [15:0] ctx_sr = '0;
  logic [31:0] ctx_pc = '0, ctx_ssp = '0, vbr = '0;
  logic        mem_valid, mem_write, mem_ready = 1'b0;
  logic [3:0]  mem_space;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [15:0] mem_wdata;
  logic        busy, done;
  logic [15:0] sr_out;
  logic [31:0] pc_out, ssp_out;

  int tests = 0, fails = 0;
  bit finished = 0;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_level(irq_level),
    .trap_req(trap_req), .trap_vec(trap_vec), .ctx_sr(ctx_sr), .ctx_pc(ctx_pc),
    .ctx_ssp(ctx_ssp), .vbr(vbr), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_space(mem_space), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .sr_out(sr_out), .pc_out(pc_out), .ssp_out(ssp_out)
  );

  always #5 clk = ~clk;

  // behavioural model state and expected access queue
  logic [15:0] m_sr;
  logic [31:0] m_pc, m_ssp;
  logic [7:0]  ack_vec = 8'h40;
  logic [3:0]  q_sp[$];
  bit          q_wr[$];
  logic [31:0] q_ad[$];
  logic [15:0] q_wd[$];

  function automatic logic [31:0] handler(input logic [31:0] a);
    return (a << 4) ^ 32'h0040_0100;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [3:0] sp, input bit wr, input logic [31:0] a,
                          input logic [15:0] d);
    q_sp.push_back(sp); q_wr.push_back(wr); q_ad.push_back(a); q_wd.push_back(d);
  endtask

  task automatic model_entry(input bit is_irq, input logic [2:0] lvl, input logic [7:0] tv);
    logic [15:0] saved;
    logic [7:0]  v;
    logic [31:0] va;
    saved = m_sr;
    m_sr[13] = 1'b1;
    m_sr[15:14] = 2'b00;
    if (is_irq) m_sr[10:8] = lvl;
    v = is_irq ? ack_vec : tv;
    if (is_irq) push_exp(4'hF, 1'b0, {28'hFFFFFFF, 1'b0, lvl}, 16'h0);
    push_exp(4'h5, 1'b1, m_ssp - 32'd2, {4'h0, 2'b00, v, 2'b00});
    push_exp(4'h5, 1'b1, m_ssp - 32'd4, m_pc[15:0]);
    push_exp(4'h5, 1'b1, m_ssp - 32'd6, m_pc[31:16]);
    push_exp(4'h5, 1'b1, m_ssp - 32'd8, saved);
    va = vbr + {22'd0, v, 2'b00};
    push_exp(4'h5, 1'b0, va, 16'h0);
    m_pc  = handler(va);
    m_ssp = m_ssp - 32'd8;
  endtask

  // memory responder with varying ready delay; checks each handshake
  initial begin
    int wait_n = 0;
    int delay = 0;
    int nacc = 0;
    logic [31:0] first_addr = '0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
      end else if (mem_valid) begin
        if (wait_n == 0) first_addr = mem_addr;
        if (wait_n < delay) begin
          wait_n++;
        end else begin
          chk(mem_addr == first_addr, "R8", "held address", mem_addr, first_addr);
          if (q_sp.size() == 0) begin
            chk(1'b0, "R6", "unexpected access", mem_addr, 32'h0);
          end else begin
            logic [3:0] sp; bit wr; logic [31:0] ad; logic [15:0] wd;
            string rq;
            sp = q_sp.pop_front(); wr = q_wr.pop_front();
            ad = q_ad.pop_front(); wd = q_wd.pop_front();
            rq = (sp == 4'hF) ? "R4" : (wr ? "R6" : "R5");
            chk(mem_space == sp, rq, "space", 32'(mem_space), 32'(sp));
            chk(mem_write == wr, rq, "direction", 32'(mem_write), 32'(wr));
            chk(mem_addr == ad, rq, "address", mem_addr, ad);
            if (wr) chk(mem_wdata == wd, rq, "write word", 32'(mem_wdata), 32'(wd));
          end
          if (mem_space == 4'hF) mem_rdata = {24'h0, ack_vec};
          else mem_rdata = handler(mem_addr);
          mem_ready = 1'b1;
          wait_n = 0;
          nacc++;
          delay = nacc % 3;
        end
      end
    end
  end

  task automatic set_ctx(input logic [15:0] s, input logic [31:0] p, input logic [31:0] sp);
    ctx_sr = s; ctx_pc = p; ctx_ssp = sp;
    m_sr = s; m_pc = p; m_ssp = sp;
  endtask

  // wait for completion, compare final state and count done pulses
  task automatic finish_entry(input string req);
    int n_done = 0;
    int cyc = 0;
    while (n_done == 0 && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (done) begin
        n_done++;
        chk(busy == 1'b0, "R11", "busy at done", 32'(busy), 32'h0);
        chk(sr_out == m_sr, "R2", "final SR", 32'(sr_out), 32'(m_sr));
        chk(sr_out[10:8] == m_sr[10:8], "R3", "mask", 32'(sr_out[10:8]), 32'(m_sr[10:8]));
        chk(pc_out == m_pc, "R5", "final PC", pc_out, m_pc);
        chk(ssp_out == m_ssp, "R7", "final SSP", ssp_out, m_ssp);
      end
    end
    if (cyc >= 2000) chk(1'b0, req, "watchdog waiting for done", 32'(cyc), 32'd0);
    repeat (4) begin
      @(negedge clk);
      if (done) n_done++;
    end
    chk(n_done == 1, req, "done pulse count", 32'(n_done), 32'd1);
    chk(q_sp.size() == 0, req, "accesses left over", 32'(q_sp.size()), 32'd0);
  endtask

  task automatic pulse(input bit irq, input bit trap);
    @(negedge clk);
    irq_req = irq; trap_req = trap;
    @(negedge clk);
    irq_req = 1'b0; trap_req = 1'b0;
  endtask

  initial begin
    vbr = 32'h0002_0000;
    repeat (3) @(negedge clk);
    chk(mem_valid == 1'b0, "R12", "mem_valid in reset", 32'(mem_valid), 32'h0);
    chk(busy == 1'b0, "R12", "busy in reset", 32'(busy), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R12", "done after reset", 32'(done), 32'h0);
    chk(mem_valid == 1'b0, "R12", "mem_valid after reset", 32'(mem_valid), 32'h0);

    // interrupt with traced SR, mask 0 -> level 5 (R1 R2 R3 R4 R6)
    set_ctx(16'hC019, 32'h1234_5678, 32'h0000_8000);
    ack_vec = 8'h40; irq_level = 3'd5;
    model_entry(1'b1, 3'd5, 8'h0);
    pulse(1'b1, 1'b0);
    finish_entry("R4");

    // trap keeps mask 2 (R3), no acknowledge cycle (R4)
    set_ctx(16'h4200, 32'h0000_0400, 32'h0000_7F00);
    trap_vec = 8'h05;
    model_entry(1'b0, 3'd0, 8'h05);
    pulse(1'b0, 1'b1);
    finish_entry("R3");

    // largest vector fills the offset field (R6), new VBR (R5)
    vbr = 32'h00F0_0000;
    set_ctx(16'h0700, 32'hDEAD_BEE0, 32'h0001_0000);
    trap_vec = 8'hFF;
    model_entry(1'b0, 3'd0, 8'hFF);
    pulse(1'b0, 1'b1);
    finish_entry("R6");

    // trap arrives mid-sequence: held, chained entry, single done (R9)
    set_ctx(16'h8000, 32'h0000_2000, 32'h0000_9000);
    ack_vec = 8'h1A; irq_level = 3'd7; trap_vec = 8'h09;
    model_entry(1'b1, 3'd7, 8'h0);
    model_entry(1'b0, 3'd0, 8'h09);
    pulse(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    ctx_sr = 16'hFFFF; ctx_pc = 32'h0; ctx_ssp = 32'h0;
    pulse(1'b0, 1'b1);
    finish_entry("R9");

    // simultaneous strobes: trap served first (R10)
    set_ctx(16'h0300, 32'h0000_6000, 32'h0000_A000);
    ack_vec = 8'h64; irq_level = 3'd4; trap_vec = 8'h0B;
    model_entry(1'b0, 3'd0, 8'h0B);
    model_entry(1'b1, 3'd4, 8'h0);
    pulse(1'b1, 1'b1);
    finish_entry("R10");

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL R11 global watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule